// File: doc/BRIEF.md
# Byte-Handshaked Disk Write Serializer

This block takes parallel bytes from a storage controller and turns them into a serial NRZ bit stream for the write path of a disk drive. One bit leaves per write-clock tick, highest data line first. The write clock is given as a one-cycle enable, `bit_en`, inside the system clock domain. Each byte arrives on an 8-bit bus with an odd-parity bit. The controller hands it over with a two-wire handshake. A strobe from the controller toggles one flip-flop. The end of each byte toggles a second one. The ready line returned to the controller is the XOR of the two.

When writing starts, the serializer first emits a run of zeros while its bit counter climbs from zero. At each later byte boundary it loads whatever is on the bus, drops ready, and carries on. If the controller has not delivered a byte in time, or is still holding its strobe high, the block flags a transfer timing error rather than stalling. A byte with even parity is flagged when the strobe falls, and writing still goes on. Both errors are sticky and drive a common fault output. A modifier input blanks the serial output without disturbing the sequencing.

Top module: `disk_write_serializer`

## Requirements
- R1: Out of reset, `ready`, `ser_out`, `err_timing`, `err_parity` and `fault` are all 0.
- R2: Each byte is sent MSB first, bit 7 down to bit 0, with `ser_out` changing to the next bit on each cycle where `bit_en` is high.
- R3: Once writing starts, `ser_out` stays 0 for the start cycle and for the next 8 ticks. The 9th tick presents bit 7 of the first byte.
- R4: A rising edge on `ctl_strobe` while `ready` is 0 raises `ready` on the following clock edge.
- R5: On the tick after a byte's bit 0, the next byte is taken from `bus_data` (its bit 7 appears on `ser_out`), and `ready` drops on that same edge.
- R6: If `ready` is 0 or `ctl_strobe` is 1 at the byte-boundary tick of R5, `err_timing` and `fault` become 1.
- R7: When `ctl_strobe` falls and `bus_data` together with `bus_par` hold an even number of ones, `err_parity` and `fault` become 1. The serial stream keeps going unchanged.
- R8: `bus_par` is never serialized: exactly 8 data bits leave per byte, and the next byte's bit 7 follows bit 0 directly.
- R9: While `inhibit` is 1, `ser_out` is 0. The bit sequence still advances, so after `inhibit` falls the bits that follow are the ones due at that point.
- R10: Writing is active only while both `wr_cmd` and `cmd_strobe` are 1. Once either drops, `ser_out` is 0 at once, and on the next edge `ready` and both error flags clear.
- R11: Error flags stay set while writing continues, even after later good handshakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | Write command from controller |
| cmd_strobe | input | 1 | Device command strobe; held high with `wr_cmd` for the whole write |
| bit_en | input | 1 | Write-clock tick, one cycle wide, never on two cycles in a row |
| ctl_strobe | input | 1 | Controller byte-valid strobe |
| bus_data | input | 8 | Parallel byte from controller |
| bus_par | input | 1 | Odd-parity bit for `bus_data` |
| inhibit | input | 1 | Data modifier: blanks the serial output |
| ready | output | 1 | Ready to the controller (XOR of the two toggle flops) |
| ser_out | output | 1 | Serial NRZ write data |
| err_timing | output | 1 | Sticky transfer timing error |
| err_parity | output | 1 | Sticky data parity error |
| fault | output | 1 | OR of the error flags |

## Verification
The hardest case to reach from the ports is a byte boundary where the controller's strobe is still high while ready is already up. Ready is 1, so only the second clause of the timing check can raise the error. The bench gets there by raising the strobe during the zero gap and simply never dropping it across the ninth tick. It then checks that the timing flag sets while the parity flag, which only a falling strobe can trigger, stays clear.

// File: rtl/dws_pkg.sv
// Package: shared widths and types for the disk write serializer.
// Assumes byte width of 8 unless overridden at the top.
package dws_pkg;
    localparam int unsigned DWS_DATA_W = 8;

    // Error pulse pair passed from detection to the sticky register.
    typedef struct packed {
        logic timing;
        logic parity;
    } dws_err_t;
endpackage

// File: rtl/dws_shifter.sv
// dws_shifter: shift register and bit counter of the serializer.
// Counter starts at 0 after write begins (zero gap) and reloads to 1 at each
// byte boundary, where the next byte is loaded MSB first.
// Assumes bit_en is never high on two consecutive cycles.
module dws_shifter #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CW = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              writing,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] data,
    output logic              ser_q,
    output logic              load_now
);
    logic [DATA_W-1:0] sr;
    logic [CW-1:0]     cnt;

    // Byte boundary: tick while the last bit of the current byte is out.
    assign load_now = writing && bit_en && (cnt == CW'(DATA_W));

    // Shift or reload on each write tick; hold cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !writing) begin
            sr    <= '0;
            cnt   <= '0;
            ser_q <= 1'b0;
        end else if (bit_en) begin
            if (cnt == CW'(DATA_W)) begin
                ser_q <= data[DATA_W-1];
                sr    <= data << 1;
                cnt   <= CW'(1);
            end else begin
                ser_q <= sr[DATA_W-1];
                sr    <= sr << 1;
                cnt   <= cnt + CW'(1);
            end
        end
    end

    // R5: a byte boundary always reloads the counter to one.
    p_cnt_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (cnt == CW'(1)));

    // R2: counter never passes the byte width.
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DATA_W));
endmodule

// File: rtl/dws_handshake.sv
// dws_handshake: two toggle flops whose XOR is the ready line, plus the
// timing and parity checks of the byte hand-over.
// Assumes ctl_strobe is synchronous to clk.
module dws_handshake #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              writing,
    input  logic              strobe,
    input  logic              load_now,
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              ready,
    output dws_pkg::dws_err_t err_pulse
);
    logic tog_a;
    logic tog_b;
    logic stb_q;
    logic stb_rise;
    logic stb_fall;

    assign ready    = tog_a ^ tog_b;
    assign stb_rise = writing && strobe && !stb_q;
    assign stb_fall = writing && !strobe && stb_q;

    // Late hand-over: boundary with no byte offered or strobe still high.
    assign err_pulse.timing = load_now && (!ready || strobe);
    // Parity sampled as the strobe falls; odd total is good.
    assign err_pulse.parity = stb_fall && !(^{data, par});

    // Strobe history and toggle flops; A follows the strobe, B the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !writing) begin
            tog_a <= 1'b0;
            tog_b <= 1'b0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= strobe;
            if (stb_rise) tog_a <= ~tog_a;
            if (load_now) tog_b <= tog_a;
        end
    end

    // R4: strobe rise with ready low raises ready.
    p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && !ready && !load_now) |=> ready);

    // R5: boundary without a simultaneous strobe rise drops ready.
    p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && !stb_rise) |=> !ready);
endmodule

// File: rtl/dws_errors.sv
// dws_errors: sticky error flags, cleared by reset or end of write.
module dws_errors (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              writing,
    input  dws_pkg::dws_err_t err_pulse,
    output logic              err_timing,
    output logic              err_parity
);
    // Capture each error pulse and hold it until writing ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !writing) begin
            err_timing <= 1'b0;
            err_parity <= 1'b0;
        end else begin
            if (err_pulse.timing) err_timing <= 1'b1;
            if (err_pulse.parity) err_parity <= 1'b1;
        end
    end

    // R11: flags hold while writing.
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (writing && (err_timing || err_parity)) |=>
            ((err_timing || !$past(err_timing)) && (err_parity || !$past(err_parity))));

    // R10: end of write clears both flags.
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !writing |=> (!err_timing && !err_parity));
endmodule

// File: rtl/disk_write_serializer.sv
// disk_write_serializer: top level. Combines write enables, gates the
// serial output and forms fault. Assumes bit_en pulses are isolated cycles.
module disk_write_serializer #(
    parameter int unsigned DATA_W = dws_pkg::DWS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              cmd_strobe,
    input  logic              bit_en,
    input  logic              ctl_strobe,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_par,
    input  logic              inhibit,
    output logic              ready,
    output logic              ser_out,
    output logic              err_timing,
    output logic              err_parity,
    output logic              fault
);
    logic              writing;
    logic              ser_q;
    logic              load_now;
    dws_pkg::dws_err_t err_pulse;

    assign writing = wr_cmd && cmd_strobe;
    assign ser_out = ser_q && writing && !inhibit;
    assign fault   = err_timing || err_parity;

    dws_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .writing  (writing),
        .bit_en   (bit_en),
        .data     (bus_data),
        .ser_q    (ser_q),
        .load_now (load_now)
    );

    dws_handshake #(.DATA_W(DATA_W)) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .writing   (writing),
        .strobe    (ctl_strobe),
        .load_now  (load_now),
        .data      (bus_data),
        .par       (bus_par),
        .ready     (ready),
        .err_pulse (err_pulse)
    );

    dws_errors u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .writing    (writing),
        .err_pulse  (err_pulse),
        .err_timing (err_timing),
        .err_parity (err_parity)
    );

    // R2: write ticks are isolated single cycles.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> !bit_en);

    // R10: ready is low one cycle after writing is off.
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !writing |=> !ready);
endmodule

// File: tb/tb_disk_write_serializer.sv
module tb_disk_write_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_cmd = 1'b0;
    logic       cmd_strobe = 1'b0;
    logic       bit_en = 1'b0;
    logic       ctl_strobe = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic       bus_par = 1'b0;
    logic       inhibit = 1'b0;
    logic       ready, ser_out, err_timing, err_parity, fault;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    disk_write_serializer dut (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .cmd_strobe(cmd_strobe),
        .bit_en(bit_en), .ctl_strobe(ctl_strobe), .bus_data(bus_data),
        .bus_par(bus_par), .inhibit(inhibit), .ready(ready), .ser_out(ser_out),
        .err_timing(err_timing), .err_parity(err_parity), .fault(fault)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One write-clock tick; outputs are settled on return.
    task automatic tick();
        @(negedge clk) bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
    endtask

    // Offer a byte: strobe high one cycle, then low; ready checked after rise.
    task automatic give_byte(logic [7:0] d, bit good);
        @(negedge clk);
        bus_data   = d;
        bus_par    = good ? ~^d : ^d;
        ctl_strobe = 1'b1;
        @(negedge clk);
        chk("R4", "ready after strobe", {7'b0, ready}, 8'h1);
        ctl_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_write();
        @(negedge clk);
        wr_cmd = 1'b1; cmd_strobe = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_write();
        @(negedge clk);
        wr_cmd = 1'b0;
        #0.1;
        chk("R10", "ser_out at stop", {7'b0, ser_out}, 8'h0);
        @(negedge clk);
        chk("R10", "ready after stop", {7'b0, ready}, 8'h0);
        chk("R10", "err_timing after stop", {7'b0, err_timing}, 8'h0);
        chk("R10", "err_parity after stop", {7'b0, err_parity}, 8'h0);
        cmd_strobe = 1'b0;
    endtask

    // Gap ticks: 8 ticks of zero after start.
    task automatic gap_ticks();
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R3", "zero gap bit", {7'b0, ser_out}, 8'h0);
        end
    endtask

    // Remaining 7 bits of a loaded byte.
    task automatic rest_bits(logic [7:0] d);
        for (int b = 6; b >= 0; b--) begin
            tick();
            chk("R2", "serial bit", {7'b0, ser_out}, {7'b0, d[b]});
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "ready", {7'b0, ready}, 8'h0);
        chk("R1", "ser_out", {7'b0, ser_out}, 8'h0);
        chk("R1", "fault", {fault, err_timing, err_parity}, 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_stream();
        logic [7:0] bytes [3] = '{8'hA5, 8'h3C, 8'hF0};
        start_write();
        chk("R3", "ser_out at start", {7'b0, ser_out}, 8'h0);
        chk("R4", "ready before strobe", {7'b0, ready}, 8'h0);
        give_byte(bytes[0], 1'b1);
        gap_ticks();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(i == 0 ? "R3" : "R8", "MSB at boundary", {7'b0, ser_out}, {7'b0, bytes[i][7]});
            chk("R5", "ready drops at load", {7'b0, ready}, 8'h0);
            if (i < 2) give_byte(bytes[i+1], 1'b1);
            rest_bits(bytes[i]);
        end
        chk("R6", "no fault on good stream", {7'b0, fault}, 8'h0);
        stop_write();
    endtask

    task automatic t_late();
        start_write();
        give_byte(8'h96, 1'b1);
        gap_ticks();
        tick();
        rest_bits(8'h96);
        tick();  // boundary with no new byte offered
        chk("R6", "timing error when not ready", {7'b0, err_timing}, 8'h1);
        chk("R6", "fault on timing", {7'b0, fault}, 8'h1);
        give_byte(8'h5A, 1'b1);
        rest_bits(8'h96);  // bus byte re-loaded was 8'h96
        tick();
        chk("R11", "timing flag sticky", {7'b0, err_timing}, 8'h1);
        stop_write();
    endtask

    task automatic t_strobe_held();
        start_write();
        @(negedge clk);
        bus_data = 8'hC3; bus_par = ~^8'hC3; ctl_strobe = 1'b1;
        gap_ticks();
        chk("R4", "ready with held strobe", {7'b0, ready}, 8'h1);
        tick();
        chk("R6", "timing error strobe high", {7'b0, err_timing}, 8'h1);
        chk("R7", "no parity error without fall", {7'b0, err_parity}, 8'h0);
        chk("R5", "byte still loaded", {7'b0, ser_out}, 8'h1);
        ctl_strobe = 1'b0;
        stop_write();
    endtask

    task automatic t_parity();
        start_write();
        give_byte(8'h81, 1'b0);
        chk("R7", "parity error flagged", {7'b0, err_parity}, 8'h1);
        chk("R7", "fault on parity", {7'b0, fault}, 8'h1);
        gap_ticks();
        tick();
        chk("R7", "stream continues MSB", {7'b0, ser_out}, 8'h1);
        rest_bits(8'h81);
        chk("R11", "parity flag sticky", {7'b0, err_parity}, 8'h1);
        stop_write();
    endtask

    task automatic t_inhibit();
        start_write();
        give_byte(8'hB7, 1'b1);
        gap_ticks();
        @(negedge clk) inhibit = 1'b1;
        tick();
        chk("R9", "inhibited MSB", {7'b0, ser_out}, 8'h0);
        tick();
        tick();
        chk("R9", "inhibited bit5", {7'b0, ser_out}, 8'h0);
        @(negedge clk) inhibit = 1'b0;
        #0.1;
        chk("R9", "bit5 after release", {7'b0, ser_out}, 8'h1);
        for (int b = 4; b >= 0; b--) begin
            tick();
            chk("R9", "bit after release", {7'b0, ser_out}, {7'b0, 8'hB7 >> b} & 8'h1);
        end
        stop_write();
    endtask

    initial begin
        t_reset();
        t_stream();
        t_late();
        t_strobe_held();
        t_parity();
        t_inhibit();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule